// File: doc/BRIEF.md
# Core low-power phase sequencer

This block steps a single core through its low-power life cycle: normal execution, an optional preparation step, a committed entry step, the idle step, and an exit step that brings the core back to execution. A request names one of four target depths with a small code: clock-gated standby, retention at reduced supply, a power-down of this core only, or a power-down of the whole cluster. The cluster power-down is granted only when every core is idle. Otherwise it is demoted to the single-core power-down.

The entry and exit steps are timed by down-counters. Each target has its own pair of cycle counts, supplied on packed input vectors. The power switch, the retention supply, the core clock gate and the core reset are driven as level outputs. Cache readiness and the system controller are handled through request and acknowledge pairs. After every sequence, whether it completes or is aborted, the remembered target goes back to standby.

Top module: `core_lp_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, phase_o is 0 (execute), tgt_o is 0, and clk_gate_o, ret_vdd_o, pwr_off_o, core_rst_o, cache_req_o and sys_req_o are all low.
- R2: With prep_en_i low, a req_i sampled in execute moves phase_o to 2 (entry) one cycle later. For a non-cluster target, entry lasts exactly L+1 cycles, where L is that target's entry count, and then phase_o reads 3 (idle).
- R3: With prep_en_i high, req_i moves phase_o to 1 (prepare). A prep_done_i pulse in prepare leads to entry one cycle later. A wake_i in prepare returns phase_o to 0 one cycle later, with tgt_o at 0 and no power output asserted.
- R4: Entry cannot be aborted. A wake_i during entry does not shorten it. The wake is held, so idle lasts exactly one cycle and exit follows.
- R5: Idle holds for as long as no wake is pending. A wake_i in idle moves phase_o to 4 (exit) one cycle later.
- R6: Exit lasts at least X+1 cycles, where X is the target's exit count. It ends on the first cycle in which the counter has reached zero and cache_ready_i is high. cache_req_o is high for the whole of exit.
- R7: clk_gate_o is high in idle for every target. ret_vdd_o is high in idle only for retention (tgt 1).
- R8: For the power-down targets (tgt 2 and 3), pwr_off_o is high in idle, and core_rst_o is high in idle and exit. core_rst_o is released on the return to execute.
- R9: Code 3 sampled while all_idle_i is low becomes tgt 2. With all_idle_i high it becomes tgt 3. For tgt 3, sys_req_o is high in entry and idle, and entry does not end until the counter is zero and sys_ack_i is high.
- R10: Codes 4 to 7 select standby (tgt 0). tgt_o reads 0 whenever phase_o is execute. Target encoding is 0 standby, 1 retention, 2 single-core power-down, 3 cluster power-down.
- R11: Entry and exit counts are taken from bits [t*CNT_W +: CNT_W] of ent_lat_i and ex_lat_i, where t is the effective target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request to leave execution |
| req_code_i | input | CODE_W | Requested depth code |
| prep_en_i | input | 1 | Use the abortable preparation step |
| prep_done_i | input | 1 | Preparation complete pulse |
| wake_i | input | 1 | Wake event |
| all_idle_i | input | 1 | Every core in the cluster is idle |
| sys_ack_i | input | 1 | System controller acknowledge |
| cache_ready_i | input | 1 | Cache hierarchy and system ready |
| ent_lat_i | input | 4*CNT_W | Entry counts, one field per target |
| ex_lat_i | input | 4*CNT_W | Exit counts, one field per target |
| clk_gate_o | output | 1 | Gate the core clock |
| ret_vdd_o | output | 1 | Select retention supply level |
| pwr_off_o | output | 1 | Open the core power switch |
| core_rst_o | output | 1 | Hold the core in warm reset |
| cache_req_o | output | 1 | Request cache and system readiness |
| sys_req_o | output | 1 | Cluster shutdown request to system controller |
| phase_o | output | 3 | Current phase: 0 exec, 1 prep, 2 entry, 3 idle, 4 exit |
| tgt_o | output | 2 | Remembered target depth |

## Verification
Every input is registered into the phase register at the next rising edge. A request, a prep_done_i, a wake in prepare or a wake in idle is therefore visible on phase_o one cycle later, and the power outputs decode from the new phase in that same cycle. The entry and exit durations are counted cycle by cycle while phase_o holds its value. They are compared with L+1 or X+1, plus the extra cycles the bench deliberately withholds sys_ack_i or cache_ready_i. Inputs change and outputs are sampled one time unit after each rising edge, so every sample falls on settled values.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int unsigned N_TGT = 4;
  localparam int unsigned TGT_W = $clog2(N_TGT);

  typedef enum logic [2:0] {
    PH_EXEC  = 3'd0,
    PH_PREP  = 3'd1,
    PH_ENTER = 3'd2,
    PH_IDLE  = 3'd3,
    PH_EXIT  = 3'd4
  } phase_e;

  typedef enum logic [TGT_W-1:0] {
    T_STBY = 2'd0,
    T_RET  = 2'd1,
    T_SPD  = 2'd2,
    T_CPD  = 2'd3
  } tgt_e;

  function automatic logic is_pd(tgt_e t);
    return (t == T_SPD) || (t == T_CPD);
  endfunction
endpackage

// File: rtl/lp_tgt_decode.sv
module lp_tgt_decode
  import lp_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              all_idle_i,
  output tgt_e              tgt_o
);
  always_comb begin
    if (int'(code_i) >= int'(N_TGT)) begin
      tgt_o = T_STBY;                        // unsupported code
    end else begin
      tgt_o = tgt_e'(code_i[TGT_W-1:0]);
      if (tgt_o == T_CPD && !all_idle_i) tgt_o = T_SPD;
    end
  end
endmodule

// File: rtl/lp_lat_timer.sv
module lp_lat_timer
  import lp_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   exit_sel_i,
  input  tgt_e                   tgt_i,
  input  logic [N_TGT*CNT_W-1:0] ent_lat_i,
  input  logic [N_TGT*CNT_W-1:0] ex_lat_i,
  output logic                   zero_o
);
  logic [CNT_W-1:0] ent_arr [N_TGT];
  logic [CNT_W-1:0] ex_arr  [N_TGT];
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < N_TGT; g++) begin : g_slot
    assign ent_arr[g] = ent_lat_i[g*CNT_W +: CNT_W];
    assign ex_arr[g]  = ex_lat_i[g*CNT_W +: CNT_W];
  end

  assign load_val = exit_sel_i ? ex_arr[tgt_i] : ent_arr[tgt_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11
endmodule

// File: rtl/lp_out_map.sv
module lp_out_map
  import lp_seq_pkg::*;
(
  input  phase_e phase_i,
  input  tgt_e   tgt_i,
  output logic   clk_gate_o,
  output logic   ret_vdd_o,
  output logic   pwr_off_o,
  output logic   core_rst_o,
  output logic   cache_req_o,
  output logic   sys_req_o
);
  logic in_idle, in_exit, pd;

  assign in_idle = (phase_i == PH_IDLE);
  assign in_exit = (phase_i == PH_EXIT);
  assign pd      = is_pd(tgt_i);

  always_comb begin
    clk_gate_o  = in_idle;
    ret_vdd_o   = in_idle && (tgt_i == T_RET);
    pwr_off_o   = in_idle && pd;
    core_rst_o  = (in_idle || in_exit) && pd;   // warm boot held through exit
    cache_req_o = in_exit;
    sys_req_o   = (tgt_i == T_CPD) && (phase_i == PH_ENTER || in_idle);
  end
endmodule

// File: rtl/core_lp_seq.sv
module core_lp_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CODE_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [CODE_W-1:0]      req_code_i,
  input  logic                   prep_en_i,
  input  logic                   prep_done_i,
  input  logic                   wake_i,
  input  logic                   all_idle_i,
  input  logic                   sys_ack_i,
  input  logic                   cache_ready_i,
  input  logic [N_TGT*CNT_W-1:0] ent_lat_i,
  input  logic [N_TGT*CNT_W-1:0] ex_lat_i,
  output logic                   clk_gate_o,
  output logic                   ret_vdd_o,
  output logic                   pwr_off_o,
  output logic                   core_rst_o,
  output logic                   cache_req_o,
  output logic                   sys_req_o,
  output logic [2:0]             phase_o,
  output logic [TGT_W-1:0]       tgt_o
);
  phase_e phase_q, phase_d;
  tgt_e   tgt_q, tgt_d, tgt_dec, tgt_sel;
  logic   pend_q, pend_d;
  logic   load, exit_sel, cnt_zero;

  lp_tgt_decode #(.CODE_W(CODE_W)) u_dec (
    .code_i     (req_code_i),
    .all_idle_i (all_idle_i),
    .tgt_o      (tgt_dec)
  );

  assign tgt_sel = (phase_q == PH_EXEC) ? tgt_dec : tgt_q;

  lp_lat_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .exit_sel_i (exit_sel),
    .tgt_i      (tgt_sel),
    .ent_lat_i  (ent_lat_i),
    .ex_lat_i   (ex_lat_i),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    phase_d  = phase_q;
    tgt_d    = tgt_q;
    pend_d   = pend_q;
    load     = 1'b0;
    exit_sel = 1'b0;
    unique case (phase_q)
      PH_EXEC: if (req_i) begin
        tgt_d = tgt_dec;
        if (prep_en_i) phase_d = PH_PREP;
        else begin
          phase_d = PH_ENTER;
          load    = 1'b1;
        end
      end
      PH_PREP: begin
        if (wake_i) begin               // abort, wake wins over done
          phase_d = PH_EXEC;
          tgt_d   = T_STBY;
        end else if (prep_done_i) begin
          phase_d = PH_ENTER;
          load    = 1'b1;
        end
      end
      PH_ENTER: begin
        if (wake_i) pend_d = 1'b1;
        if (cnt_zero && (tgt_q != T_CPD || sys_ack_i)) phase_d = PH_IDLE;
      end
      PH_IDLE: if (wake_i || pend_q) begin
        phase_d  = PH_EXIT;
        load     = 1'b1;
        exit_sel = 1'b1;
        pend_d   = 1'b0;
      end
      PH_EXIT: if (cnt_zero && cache_ready_i) begin
        phase_d = PH_EXEC;
        tgt_d   = T_STBY;                // default depth after any sequence
      end
      default: begin
        phase_d = PH_EXEC;
        tgt_d   = T_STBY;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EXEC;
      tgt_q   <= T_STBY;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tgt_q   <= tgt_d;
      pend_q  <= pend_d;
    end
  end

  lp_out_map u_out (
    .phase_i     (phase_q),
    .tgt_i       (tgt_q),
    .clk_gate_o  (clk_gate_o),
    .ret_vdd_o   (ret_vdd_o),
    .pwr_off_o   (pwr_off_o),
    .core_rst_o  (core_rst_o),
    .cache_req_o (cache_req_o),
    .sys_req_o   (sys_req_o)
  );

  assign phase_o = phase_q;
  assign tgt_o   = tgt_q;

  AST_PREP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PREP && wake_i) |=> (phase_q == PH_EXEC && !clk_gate_o)); // R3
  AST_ENTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENTER && !cnt_zero) |=> (phase_q == PH_ENTER)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !wake_i && !pend_q) |=> (phase_q == PH_IDLE)); // R5
  AST_EXIT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXIT && !cache_ready_i) |=> (phase_q == PH_EXIT)); // R6
  AST_PWR_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> (core_rst_o && !ret_vdd_o)); // R8
  AST_CPD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && req_i && !all_idle_i) |=> (tgt_o != T_CPD)); // R9
  AST_CPD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENTER && tgt_q == T_CPD && !sys_ack_i) |=> (phase_q == PH_ENTER)); // R9
  AST_EXEC_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC) |-> (tgt_o == T_STBY)); // R10
endmodule

// File: tb/tb_core_lp_seq.sv
module tb_core_lp_seq;
  localparam int CNT_W = 8;
  localparam int CODE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, prep_en = 0, prep_done = 0, wake = 0, all_idle = 0;
  logic sys_ack = 0, cache_rdy = 0;
  logic [CODE_W-1:0] code = '0;
  logic [4*CNT_W-1:0] ent_lat = '0, ex_lat = '0;
  logic clk_gate, ret_vdd, pwr_off, core_rst, cache_req, sys_req;
  logic [2:0] phase;
  logic [1:0] tgt;

  int checks = 0, errors = 0;
  int el [4];
  int xl [4];

  always #5 clk = ~clk;

  core_lp_seq #(.CNT_W(CNT_W), .CODE_W(CODE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_code_i(code),
    .prep_en_i(prep_en), .prep_done_i(prep_done), .wake_i(wake),
    .all_idle_i(all_idle), .sys_ack_i(sys_ack), .cache_ready_i(cache_rdy),
    .ent_lat_i(ent_lat), .ex_lat_i(ex_lat),
    .clk_gate_o(clk_gate), .ret_vdd_o(ret_vdd), .pwr_off_o(pwr_off),
    .core_rst_o(core_rst), .cache_req_o(cache_req), .sys_req_o(sys_req),
    .phase_o(phase), .tgt_o(tgt)
  );

  task automatic chk(string req_tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int exp_tgt(int c, bit ai);
    if (c >= 4) return 0;
    if (c == 3 && !ai) return 2;
    return c;
  endfunction

  task automatic set_lat(int s);
    for (int t = 0; t < 4; t++) begin
      el[t] = (s == 0) ? t + 1 : 0;
      xl[t] = (s == 0) ? 2 * t + 1 : 0;
      ent_lat[t*CNT_W +: CNT_W] = CNT_W'(el[t]);
      ex_lat[t*CNT_W +: CNT_W]  = CNT_W'(xl[t]);
    end
  endtask

  task automatic idle_outs(int t);
    chk("R7 clk_gate", int'(clk_gate), 1);
    chk("R7 ret_vdd", int'(ret_vdd), int'(t == 1));
    chk("R8 pwr_off", int'(pwr_off), int'(t >= 2));
    chk("R8 core_rst idle", int'(core_rst), int'(t >= 2));
    chk("R9 sys_req idle", int'(sys_req), int'(t == 3));
    chk("R10 tgt", int'(tgt), t);
  endtask

  task automatic seq(int c, bit ai, bit pe, bit we);
    int t, n, late;
    t = exp_tgt(c, ai);
    late = c % 2;
    code = CODE_W'(c); all_idle = ai; prep_en = pe; req = 1;
    step();
    req = 0;
    if (pe) begin
      chk("R3 prep", int'(phase), 1);
      step();
      chk("R3 prep hold", int'(phase), 1);
      prep_done = 1;
      step();
      prep_done = 0;
    end
    chk("R2 entry", int'(phase), 2);
    n = 0;
    while (phase == 3'd2 && n < 300) begin
      chk("R9 sys_req entry", int'(sys_req), int'(t == 3));
      n++;
      wake = we && (n == 1);
      if (t == 3 && n == el[t] + 3) sys_ack = 1;
      step();
    end
    wake = 0;
    chk("R2/R11 entry length", n, (t == 3) ? el[t] + 3 : el[t] + 1);
    chk("R2 idle reached", int'(phase), 3);
    idle_outs(t);
    if (we) begin
      step();
      chk("R4 held wake exit", int'(phase), 4);
    end else begin
      for (int i = 0; i < 4; i++) begin
        step();
        chk("R5 idle hold", int'(phase), 3);
      end
      wake = 1;
      step();
      wake = 0;
      chk("R5 wake exit", int'(phase), 4);
    end
    cache_rdy = (late == 0);
    n = 0;
    while (phase == 3'd4 && n < 300) begin
      chk("R6 cache_req", int'(cache_req), 1);
      chk("R8 core_rst exit", int'(core_rst), int'(t >= 2));
      n++;
      if (late == 1 && n == xl[t] + 2) cache_rdy = 1;
      step();
    end
    chk("R6/R11 exit length", n, xl[t] + 1 + late);
    chk("R6 back exec", int'(phase), 0);
    chk("R10 default stby", int'(tgt), 0);
    chk("R8 rst released", int'(core_rst), 0);
    cache_rdy = 0; sys_ack = 0;
    step();
  endtask

  task automatic abort_seq(int c);
    code = CODE_W'(c); all_idle = 1; prep_en = 1; req = 1;
    step();
    req = 0;
    chk("R3 prep", int'(phase), 1);
    wake = 1;
    step();
    wake = 0;
    chk("R3 abort phase", int'(phase), 0);
    chk("R3 abort tgt", int'(tgt), 0);
    chk("R3 abort gate", int'(clk_gate | pwr_off | core_rst | ret_vdd), 0);
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_lat(0);
    #22;
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 outs in reset", int'({clk_gate, ret_vdd, pwr_off, core_rst, cache_req, sys_req}), 0);
    rst_n = 1;
    step();
    chk("R1 phase", int'(phase), 0);
    chk("R1 tgt", int'(tgt), 0);
    chk("R1 outs", int'({clk_gate, ret_vdd, pwr_off, core_rst, cache_req, sys_req}), 0);
    for (int s = 0; s < 2; s++) begin
      set_lat(s);
      for (int c = 0; c < 8; c++)
        for (int ai = 0; ai < 2; ai++)
          for (int pe = 0; pe < 2; pe++)
            for (int we = 0; we < 2; we++)
              seq(c, ai[0], pe[0], we[0]);
      for (int c = 0; c < 4; c++) begin
        abort_seq(c);
        seq(c, 1'b1, 1'b0, 1'b0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule